// File: doc/BRIEF.md
# Dual-Word Gain Selection Multiplexer

This block sits after the digital correction stage of a readout front end with three gain channels. In every sample period it takes one 12-bit code from each of the low, medium and high gain paths. It sends two words per sample on a single 12-bit bus that runs at twice the sample rate. The first word of each pair is always the medium-gain code. The second word is the high-gain code while that code stays below a saturation threshold, and the low-gain code otherwise. An external force input overrides the automatic choice and always selects the low-gain code.

A frame strobe marks the first word of every pair. A one-bit gain tag travels with the second word, so that downstream logic knows which scale factor to apply. The block runs on the word clock, and the sample period is every other edge of that clock. The three codes and the force level are captured together on one edge, so both words of a pair come from the same sample.

Top module: `gain_pair_mux`

## Requirements
- R1: While reset is held, and after reset until the first sample has been captured, `word_o` is 0, `frame_o` is 0 and `gain_tag_o` is 0.
- R2: In the cycle where `frame_o` is 1, `word_o` carries the medium-gain code of the captured sample.
- R3: With force inactive and a high-gain code strictly below `SAT_THRESH` (default 4000), the cycle after the frame cycle carries the high-gain code, with `gain_tag_o` = 0 (0 means high gain).
- R4: With force inactive and a high-gain code equal to or above `SAT_THRESH`, the second word is the low-gain code, with `gain_tag_o` = 1 (1 means low gain). The value 4000 selects low gain and 3999 selects high gain.
- R5: While the synchronized force input is 1 at capture time, the second word is the low-gain code with `gain_tag_o` = 1, whatever the high-gain code is. When force returns to 0, automatic selection resumes.
- R6: Once frames have started, `frame_o` is 1 on every other cycle and is never 1 on two consecutive cycles.
- R7: Both words of a pair come from one capture edge. A change on the code inputs after that edge does not alter the second word of the pair in flight. The change appears in the next pair.
- R8: `gain_tag_o` is 0 in every frame cycle, and `frame_o` is 0 in every second-word cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock (twice the sample rate) |
| rst_ni | input | 1 | Active-low synchronous reset |
| lo_code_i | input | 12 | Low-gain corrected code |
| md_code_i | input | 12 | Medium-gain corrected code |
| hi_code_i | input | 12 | High-gain corrected code |
| force_low_i | input | 1 | Asynchronous request to always send low gain as the second word |
| word_o | output | 12 | Multiplexed output word |
| frame_o | output | 1 | High on the medium-gain word of each pair |
| gain_tag_o | output | 1 | Gain of the second word: 0 high, 1 low |

## Verification
The bench builds the block with its defaults: a 12-bit code, a threshold of 4000 and a two-stage force synchronizer. These values put the exact threshold boundary (3999 against 4000) and the full-scale code 4095 within reach of directed vectors. The bench finds each pair by its frame strobe. It changes the code inputs in the middle of a pair to show that the word in flight keeps its sample. It also holds force long enough to cross the synchronizer and then releases it.

// File: rtl/gsel_pkg.sv
package gsel_pkg;
    typedef enum logic {
        TAG_HIGH = 1'b0,
        TAG_LOW  = 1'b1
    } gain_tag_e;
endpackage

// File: rtl/gsel_capture.sv
module gsel_capture #(
    parameter int CODE_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cap_en_i,
    input  logic [CODE_W-1:0] lo_i,
    input  logic [CODE_W-1:0] md_i,
    input  logic [CODE_W-1:0] hi_i,
    input  logic              force_async_i,
    output logic [CODE_W-1:0] lo_q_o,
    output logic [CODE_W-1:0] md_q_o,
    output logic [CODE_W-1:0] hi_q_o,
    output logic              force_q_o,
    output logic              valid_o
);
    typedef struct packed {
        logic [CODE_W-1:0]      lo;
        logic [CODE_W-1:0]      md;
        logic [CODE_W-1:0]      hi;
        logic                   frc;
        logic                   vld;
        logic [SYNC_STAGES-1:0] sync;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (SYNC_STAGES > 1) begin
            st_d.sync = {st_q.sync[SYNC_STAGES-2:0], force_async_i};
        end else begin
            st_d.sync[0] = force_async_i;
        end
        if (cap_en_i) begin
            st_d.lo  = lo_i;
            st_d.md  = md_i;
            st_d.hi  = hi_i;
            st_d.frc = st_q.sync[SYNC_STAGES-1];
            st_d.vld = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign lo_q_o    = st_q.lo;
    assign md_q_o    = st_q.md;
    assign hi_q_o    = st_q.hi;
    assign force_q_o = st_q.frc;
    assign valid_o   = st_q.vld;

    // R7
    sample_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cap_en_i |=> ($stable(md_q_o) && $stable(hi_q_o) && $stable(lo_q_o) && $stable(force_q_o)));
endmodule

// File: rtl/gsel_choose.sv
module gsel_choose
    import gsel_pkg::*;
#(
    parameter int CODE_W     = 12,
    parameter int SAT_THRESH = 4000
) (
    input  logic [CODE_W-1:0] lo_i,
    input  logic [CODE_W-1:0] hi_i,
    input  logic              force_i,
    output logic [CODE_W-1:0] sel_o,
    output gain_tag_e         tag_o
);
    localparam logic [CODE_W-1:0] THR = CODE_W'(SAT_THRESH);

    logic hi_ok;

    always_comb begin
        hi_ok = !force_i && (hi_i < THR);
        sel_o = hi_ok ? hi_i : lo_i;
        tag_o = hi_ok ? TAG_HIGH : TAG_LOW;
    end
endmodule

// File: rtl/gsel_serialize.sv
module gsel_serialize
    import gsel_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              valid_i,
    input  logic [CODE_W-1:0] md_i,
    input  logic [CODE_W-1:0] sel_i,
    input  gain_tag_e         tag_i,
    output logic              cap_en_o,
    output logic [CODE_W-1:0] word_o,
    output logic              frame_o,
    output logic              tag_o
);
    typedef struct packed {
        logic              phase;
        logic              started;
        logic [CODE_W-1:0] word;
        logic              frame;
        logic              tag;
    } ser_state_t;

    ser_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.phase = ~st_q.phase;
        if (valid_i) begin
            if (st_q.phase) begin
                st_d.word    = md_i;
                st_d.frame   = 1'b1;
                st_d.tag     = 1'b0;
                st_d.started = 1'b1;
            end else begin
                st_d.word  = sel_i;
                st_d.frame = 1'b0;
                st_d.tag   = (tag_i == TAG_LOW);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cap_en_o = ~st_q.phase;
    assign word_o   = st_q.word;
    assign frame_o  = st_q.frame;
    assign tag_o    = st_q.tag;

    // R6
    frame_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_o |=> !frame_o);
    // R6
    frame_cadence_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.started && !frame_o) |=> frame_o);
    // R8
    frame_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_o |-> !tag_o);
    // R2
    frame_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_o |-> (word_o == md_i));
    // R1
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.started |-> (word_o == '0 && !frame_o && !tag_o));
endmodule

// File: rtl/gain_pair_mux.sv
module gain_pair_mux
    import gsel_pkg::*;
#(
    parameter int CODE_W      = 12,
    parameter int SAT_THRESH  = 4000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CODE_W-1:0] lo_code_i,
    input  logic [CODE_W-1:0] md_code_i,
    input  logic [CODE_W-1:0] hi_code_i,
    input  logic              force_low_i,
    output logic [CODE_W-1:0] word_o,
    output logic              frame_o,
    output logic              gain_tag_o
);
    localparam logic [CODE_W-1:0] THR = CODE_W'(SAT_THRESH);

    logic              cap_en;
    logic [CODE_W-1:0] lo_q, md_q, hi_q, sel;
    logic              frc_q, vld;
    gain_tag_e         sel_tag;

    gsel_capture #(.CODE_W(CODE_W), .SYNC_STAGES(SYNC_STAGES)) i_capture (
        .clk_i(clk_i), .rst_ni(rst_ni), .cap_en_i(cap_en),
        .lo_i(lo_code_i), .md_i(md_code_i), .hi_i(hi_code_i),
        .force_async_i(force_low_i),
        .lo_q_o(lo_q), .md_q_o(md_q), .hi_q_o(hi_q),
        .force_q_o(frc_q), .valid_o(vld)
    );

    gsel_choose #(.CODE_W(CODE_W), .SAT_THRESH(SAT_THRESH)) i_choose (
        .lo_i(lo_q), .hi_i(hi_q), .force_i(frc_q),
        .sel_o(sel), .tag_o(sel_tag)
    );

    gsel_serialize #(.CODE_W(CODE_W)) i_serialize (
        .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(vld),
        .md_i(md_q), .sel_i(sel), .tag_i(sel_tag),
        .cap_en_o(cap_en), .word_o(word_o), .frame_o(frame_o), .tag_o(gain_tag_o)
    );

    // R3
    high_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_o && !frc_q && hi_q < THR) |=> (!gain_tag_o && word_o == $past(hi_q)));
    // R4
    sat_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_o && !frc_q && hi_q >= THR) |=> (gain_tag_o && word_o == $past(lo_q)));
    // R5
    force_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_o && frc_q) |=> (gain_tag_o && word_o == $past(lo_q)));
    // R8
    second_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_o |=> !frame_o);
endmodule

// File: tb/test_gain_pair_mux.sv
module test_gain_pair_mux;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] lo = '0, md = '0, hi = '0;
    logic        frc = 1'b0;
    logic [11:0] word;
    logic        frame, tag;
    int          n_vec = 0, n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    gain_pair_mux i_gain_pair_mux (
        .clk_i(clk), .rst_ni(rst_n), .lo_code_i(lo), .md_code_i(md), .hi_code_i(hi),
        .force_low_i(frc), .word_o(word), .frame_o(frame), .gain_tag_o(tag)
    );

    task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic find_frame();
        for (int i = 0; i < 4; i++) begin
            if (frame === 1'b1) break;
            @(negedge clk);
        end
    endtask

    task automatic run_pair(input string req, input logic [11:0] l, input logic [11:0] m,
                            input logic [11:0] h, input logic f,
                            input logic [11:0] exp_w, input logic exp_t);
        @(negedge clk);
        lo = l; md = m; hi = h; frc = f;
        repeat (8) @(negedge clk);
        find_frame();
        chk({req, " frame"}, 12'(frame), 12'd1);
        chk("R2 medium word", word, m);
        chk("R8 tag on frame", 12'(tag), 12'd0);
        @(negedge clk);
        chk({req, " second word"}, word, exp_w);
        chk({req, " tag"}, 12'(tag), 12'(exp_t));
        chk("R8 frame on second word", 12'(frame), 12'd0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 word", word, 12'd0);
        chk("R1 frame", 12'(frame), 12'd0);
        chk("R1 tag", 12'(tag), 12'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 word before capture", word, 12'd0);
        chk("R1 frame before capture", 12'(frame), 12'd0);
    endtask

    task automatic t_cadence();
        logic prev;
        find_frame();
        prev = frame;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R6 alternation", 12'(frame), 12'(!prev));
            prev = frame;
        end
    endtask

    task automatic t_midpair();
        @(negedge clk);
        lo = 12'd7; md = 12'd111; hi = 12'd200; frc = 1'b0;
        repeat (8) @(negedge clk);
        find_frame();
        lo = 12'd9; md = 12'd222; hi = 12'd300;
        @(negedge clk);
        chk("R7 word in flight", word, 12'd200);
        @(negedge clk);
        chk("R7 next frame", 12'(frame), 12'd1);
        chk("R7 next medium", word, 12'd222);
        @(negedge clk);
        chk("R7 next second word", word, 12'd300);
    endtask

    initial begin
        t_reset();
        run_pair("R3 low code", 12'd50, 12'd400, 12'd100, 1'b0, 12'd100, 1'b0);
        run_pair("R3 just below", 12'd60, 12'd480, 12'd3999, 1'b0, 12'd3999, 1'b0);
        run_pair("R4 at threshold", 12'd61, 12'd485, 12'd4000, 1'b0, 12'd61, 1'b1);
        run_pair("R4 full scale", 12'd500, 12'd4095, 12'd4095, 1'b0, 12'd500, 1'b1);
        run_pair("R5 forced", 12'd33, 12'd44, 12'd10, 1'b1, 12'd33, 1'b1);
        run_pair("R5 released", 12'd33, 12'd44, 12'd10, 1'b0, 12'd10, 1'b0);
        t_cadence();
        t_midpair();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule